// File: doc/BRIEF.md
# Dual Prescaled Reload Timer

This block holds two 8-bit up-counting timers that run side by side. Each timer owns a reload register, a count register, an option register and an 8-bit prescaler that sets how many clock cycles pass between count steps. When a step would carry the count past its all-ones value, the count takes the reload value instead of rolling over to zero. The timer raises a one-cycle overflow pulse as it does so. Software can therefore set the period by choosing the reload value, and set the step rate by choosing the prescaler ratio.

Both timers share one small register window. A single select input decides which timer's registers a read or write reaches. The select input only steers register access: both timers keep counting whether or not they are visible. In the window, offset 0 holds the reload value, offset 1 holds the live count and offset 2 holds the option byte. The option byte has the enable flag in bit 3 and the ratio code in bits 2:0. Writing the live count also restarts that timer's prescaler, so software gets a known phase for the first step.

Top module: `dual_timer`

## Requirements
- R1: After reset, the reload, count and option registers of both timers read 0, so both timers are disabled, and neither overflow pulse is high.
- R2: With `timerSel` at 0 or 1, reads and writes at offsets 0 (reload), 1 (count) and 2 (option) reach only the registers of timer 0 or timer 1 respectively. A write leaves the other timer's registers unchanged.
- R3: A timer that is enabled keeps stepping while the other timer is selected.
- R4: With option bit 3 set and option bits 2:0 equal to d, the count of an enabled timer rises by one every 2^(d+1) clock cycles, counting from the last write to its count register. This gives ratios from 2 up to 256.
- R5: A step taken while the count is 0xFF loads the count with the reload value, and raises that timer's `ovfPulse` bit for the following cycle.
- R6: While option bit 3 is clear, a timer holds both its count and its prescaler phase. After the timer is enabled again, stepping resumes from the held phase.
- R7: A write to the count register sets the count to the written byte and clears the prescaler. When that write falls on a step cycle, the write takes priority over the step.
- R8: An overflow pulse lasts exactly one cycle. It appears only in the cycle after a wrap.
- R9: Offset 3 reads as 0, and writes to offset 3 change no timer register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 2 | Register offset within the shared window |
| regWrData | input | 8 | Write data |
| regWrEn | input | 1 | Write strobe, one write per high cycle |
| timerSel | input | 1 | Selects which timer the window reaches |
| regRdData | output | 8 | Combinational read data for `regAddr` and `timerSel` |
| ovfPulse | output | 2 | One-cycle overflow pulse per timer, bit i for timer i |

## Verification
The properties take for granted that `regAddr`, `timerSel`, `regWrData` and `regWrEn` are known and stable across each rising edge. They also assume a write to the count register is not paired, on the very next cycle, with a read that expects the pre-write value. The reload property further relies on the reload register of the same timer not being rewritten at the wrap edge, and it excuses exactly that case. The stimulus changes every input one nanosecond after a rising edge and issues at most one write per cycle. It places every count write on an edge it has counted from the previous write, so the checked values never straddle a step.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int TMR_N   = 2;
  localparam int TMR_DW  = 8;
  localparam int ADDR_W  = 2;
  localparam int SEL_W   = (TMR_N > 1) ? $clog2(TMR_N) : 1;
  localparam int DIV_W   = 3;
  localparam int PRE_W   = 2 ** DIV_W;
  localparam int EN_BIT  = DIV_W;

  typedef enum logic [ADDR_W-1:0] {
    REG_LOAD  = 2'd0,
    REG_COUNT = 2'd1,
    REG_OPT   = 2'd2,
    REG_NONE  = 2'd3
  } regOfs_e;

  typedef struct packed {
    logic [TMR_N-1:0]  wrLoad;
    logic [TMR_N-1:0]  wrCount;
    logic [TMR_N-1:0]  wrOpt;
    logic [TMR_DW-1:0] data;
  } tmrStrobe_t;
endpackage

// File: rtl/dtmr_ctrl.sv
module dtmr_ctrl
  import dtmr_pkg::*;
(
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [TMR_DW-1:0]            regWrData,
  input  logic                         regWrEn,
  input  logic [SEL_W-1:0]             timerSel,
  input  logic [TMR_N-1:0][TMR_DW-1:0] loadAll,
  input  logic [TMR_N-1:0][TMR_DW-1:0] countAll,
  input  logic [TMR_N-1:0][TMR_DW-1:0] optAll,
  output tmrStrobe_t                   strobe,
  output logic [TMR_DW-1:0]            regRdData
);
  // Write decode: one strobe bit for the selected timer only
  always_comb begin
    strobe      = '0;
    strobe.data = regWrData;
    if (regWrEn) begin
      case (regAddr)
        REG_LOAD:  strobe.wrLoad[timerSel]  = 1'b1;
        REG_COUNT: strobe.wrCount[timerSel] = 1'b1;
        REG_OPT:   strobe.wrOpt[timerSel]   = 1'b1;
        default:   ;
      endcase
    end
  end

  // Read mux through the shared window
  always_comb begin
    case (regAddr)
      REG_LOAD:  regRdData = loadAll[timerSel];
      REG_COUNT: regRdData = countAll[timerSel];
      REG_OPT:   regRdData = optAll[timerSel];
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/dtmr_unit.sv
module dtmr_unit
  import dtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrLoad,
  input  logic              wrCount,
  input  logic              wrOpt,
  input  logic [TMR_DW-1:0] wrData,
  output logic [TMR_DW-1:0] loadQ,
  output logic [TMR_DW-1:0] countQ,
  output logic [TMR_DW-1:0] optQ,
  output logic              ovf
);
  localparam logic [DIV_W-1:0] TOP_DIV = DIV_W'(PRE_W - 1);

  logic [PRE_W-1:0] preQ;
  logic [PRE_W-1:0] preLimit;
  logic             enable;
  logic             tick;

  assign enable   = optQ[EN_BIT];
  // 2^(d+1)-1: all-ones mask of d+1 bits
  assign preLimit = {PRE_W{1'b1}} >> (TOP_DIV - optQ[DIV_W-1:0]);
  assign tick     = enable && (preQ >= preLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadQ  <= '0;
      countQ <= '0;
      optQ   <= '0;
      preQ   <= '0;
      ovf    <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (wrLoad) loadQ <= wrData;
      if (wrOpt)  optQ  <= wrData;
      if (wrCount) begin
        countQ <= wrData;
        preQ   <= '0;
      end else if (tick) begin
        preQ <= '0;
        if (countQ == '1) begin
          countQ <= loadQ;
          ovf    <= 1'b1;
        end else begin
          countQ <= countQ + 1'b1;
        end
      end else if (enable) begin
        preQ <= preQ + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dtmr_dp.sv
module dtmr_dp
  import dtmr_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  tmrStrobe_t                   strobe,
  output logic [TMR_N-1:0][TMR_DW-1:0] loadAll,
  output logic [TMR_N-1:0][TMR_DW-1:0] countAll,
  output logic [TMR_N-1:0][TMR_DW-1:0] optAll,
  output logic [TMR_N-1:0]             ovfPulse
);
  for (genvar i = 0; i < TMR_N; i++) begin : g_tmr
    dtmr_unit u_unit (
      .clk     (clk),
      .rstN    (rstN),
      .wrLoad  (strobe.wrLoad[i]),
      .wrCount (strobe.wrCount[i]),
      .wrOpt   (strobe.wrOpt[i]),
      .wrData  (strobe.data),
      .loadQ   (loadAll[i]),
      .countQ  (countAll[i]),
      .optQ    (optAll[i]),
      .ovf     (ovfPulse[i])
    );
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [TMR_DW-1:0] regWrData,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  timerSel,
  output logic [TMR_DW-1:0] regRdData,
  output logic [TMR_N-1:0]  ovfPulse
);
  tmrStrobe_t                   strobe;
  logic [TMR_N-1:0][TMR_DW-1:0] loadAll;
  logic [TMR_N-1:0][TMR_DW-1:0] countAll;
  logic [TMR_N-1:0][TMR_DW-1:0] optAll;

  dtmr_ctrl u_ctrl (
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWrEn   (regWrEn),
    .timerSel  (timerSel),
    .loadAll   (loadAll),
    .countAll  (countAll),
    .optAll    (optAll),
    .strobe    (strobe),
    .regRdData (regRdData)
  );

  dtmr_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadAll  (loadAll),
    .countAll (countAll),
    .optAll   (optAll),
    .ovfPulse (ovfPulse)
  );
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import dtmr_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic [ADDR_W-1:0]            regAddr,
  input logic [TMR_DW-1:0]            regWrData,
  input logic                         regWrEn,
  input logic [SEL_W-1:0]             timerSel,
  input logic [TMR_DW-1:0]            regRdData,
  input logic [TMR_N-1:0]             ovfPulse,
  input logic [TMR_N-1:0][TMR_DW-1:0] loadAll,
  input logic [TMR_N-1:0][TMR_DW-1:0] countAll,
  input logic [TMR_N-1:0][TMR_DW-1:0] optAll
);
  // R9
  unused_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_NONE) |-> (regRdData == '0));

  for (genvar i = 0; i < TMR_N; i++) begin : g_chk
    // R8
    ovf_single_chk: assert property (@(posedge clk) disable iff (!rstN)
      ovfPulse[i] |=> !ovfPulse[i]);

    // R5
    ovf_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ovfPulse[i] && !$past(regWrEn && regAddr == REG_LOAD && timerSel == SEL_W'(i)))
        |-> (countAll[i] == loadAll[i]));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!optAll[i][EN_BIT] && !(regWrEn && regAddr == REG_COUNT && timerSel == SEL_W'(i)))
        |=> $stable(countAll[i]));

    // R7
    count_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == REG_COUNT && timerSel == SEL_W'(i))
        |=> (countAll[i] == $past(regWrData)));

    // R2
    opt_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == REG_OPT && timerSel == SEL_W'(i))
        |=> (optAll[i] == $past(regWrData)));
  end
endmodule

bind dual_timer dual_timer_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regWrEn   (regWrEn),
  .timerSel  (timerSel),
  .regRdData (regRdData),
  .ovfPulse  (ovfPulse),
  .loadAll   (loadAll),
  .countAll  (countAll),
  .optAll    (optAll)
);

// File: tb/tb_dual_timer.sv
`timescale 1ns/1ps
module tb_dual_timer;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] regAddr;
  logic [7:0] regWrData;
  logic       regWrEn;
  logic       timerSel;
  logic [7:0] regRdData;
  logic [1:0] ovfPulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] rd;
    logic [1:0] ovf;
    bit         chkOvf;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  dual_timer dut (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWrEn   (regWrEn),
    .timerSel  (timerSel),
    .regRdData (regRdData),
    .ovfPulse  (ovfPulse)
  );

  // Monitor: pops one expected item per cycle, samples at the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (regRdData !== e.rd || (e.chkOvf && ovfPulse !== e.ovf)) begin
        errors++;
        $display("FAIL %s: rd=%02h ovf=%b expected rd=%02h ovf=%b",
                 e.tag, regRdData, ovfPulse, e.rd, e.chkOvf ? e.ovf : ovfPulse);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic s, input logic [7:0] d);
    regAddr = a; timerSel = s; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic expRd(input logic [1:0] a, input logic s, input logic [7:0] v,
                       input string tag);
    regAddr = a; timerSel = s;
    expQ.push_back('{rd: v, ovf: 2'b00, chkOvf: 1'b0, tag: tag});
    @(posedge clk); #1;
  endtask

  task automatic expRdOvf(input logic [1:0] a, input logic s, input logic [7:0] v,
                          input logic [1:0] o, input string tag);
    regAddr = a; timerSel = s;
    expQ.push_back('{rd: v, ovf: o, chkOvf: 1'b1, tag: tag});
    @(posedge clk); #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0; timerSel = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state of both timers
    expRdOvf(2'd0, 1'b0, 8'h00, 2'b00, "R1 load0");
    expRd(2'd1, 1'b0, 8'h00, "R1 count0");
    expRd(2'd2, 1'b0, 8'h00, "R1 opt0");
    expRd(2'd0, 1'b1, 8'h00, "R1 load1");
    expRd(2'd1, 1'b1, 8'h00, "R1 count1");
    expRdOvf(2'd2, 1'b1, 8'h00, 2'b00, "R1 opt1");

    // R2 select steers writes; R9 offset 3 is inert
    wr(2'd0, 1'b0, 8'h11);
    wr(2'd0, 1'b1, 8'h22);
    expRd(2'd0, 1'b0, 8'h11, "R2 load0");
    expRd(2'd0, 1'b1, 8'h22, "R2 load1");
    wr(2'd3, 1'b0, 8'h55);
    expRd(2'd3, 1'b0, 8'h00, "R9 read zero");
    expRd(2'd0, 1'b0, 8'h11, "R9 write ignored");
    expRd(2'd1, 1'b1, 8'h00, "R2 count1 idle");

    // R4 ratio 2
    wr(2'd2, 1'b0, 8'h08);
    wr(2'd1, 1'b0, 8'h10);
    expRd(2'd1, 1'b0, 8'h10, "R4 r2 t0");
    expRd(2'd1, 1'b0, 8'h10, "R4 r2 t1");
    expRd(2'd1, 1'b0, 8'h11, "R4 r2 t2");
    expRd(2'd1, 1'b0, 8'h11, "R4 r2 t3");
    expRd(2'd1, 1'b0, 8'h12, "R4 r2 t4");
    // R4 ratio 8
    wr(2'd2, 1'b0, 8'h0A);
    wr(2'd1, 1'b0, 8'h40);
    expRd(2'd1, 1'b0, 8'h40, "R4 r8 t0");
    step(6);
    expRd(2'd1, 1'b0, 8'h40, "R4 r8 t7");
    expRd(2'd1, 1'b0, 8'h41, "R4 r8 t8");
    // R4 ratio 256
    wr(2'd2, 1'b0, 8'h0F);
    wr(2'd1, 1'b0, 8'h00);
    step(255);
    expRd(2'd1, 1'b0, 8'h00, "R4 r256 t255");
    expRd(2'd1, 1'b0, 8'h01, "R4 r256 t256");

    // R5 / R8 wrap to reload with a single pulse
    wr(2'd2, 1'b0, 8'h08);
    wr(2'd0, 1'b0, 8'hF0);
    wr(2'd1, 1'b0, 8'hFE);
    step(3);
    expRdOvf(2'd1, 1'b0, 8'hFF, 2'b00, "R5 before wrap");
    expRdOvf(2'd1, 1'b0, 8'hF0, 2'b01, "R5 wrap reload");
    expRdOvf(2'd1, 1'b0, 8'hF0, 2'b00, "R8 pulse one cycle");

    // R7 write on a step edge wins
    wr(2'd1, 1'b0, 8'h50);
    step(1);
    wr(2'd1, 1'b0, 8'h60);
    expRd(2'd1, 1'b0, 8'h60, "R7 write wins");
    expRd(2'd1, 1'b0, 8'h60, "R7 prescaler cleared");
    expRd(2'd1, 1'b0, 8'h61, "R7 next step");

    // R6 disable holds count and prescaler phase
    wr(2'd1, 1'b0, 8'h30);
    wr(2'd2, 1'b0, 8'h00);
    expRd(2'd1, 1'b0, 8'h30, "R6 held a");
    step(10);
    expRd(2'd1, 1'b0, 8'h30, "R6 held b");
    wr(2'd2, 1'b0, 8'h08);
    expRd(2'd1, 1'b0, 8'h30, "R6 re-enabled");
    expRd(2'd1, 1'b0, 8'h31, "R6 phase kept");

    // R3 unselected timer keeps counting
    wr(2'd2, 1'b1, 8'h09);
    wr(2'd1, 1'b1, 8'h80);
    wr(2'd0, 1'b0, 8'h77);
    expRd(2'd0, 1'b0, 8'h77, "R2 load0 rewrite");
    step(18);
    expRd(2'd1, 1'b1, 8'h85, "R3 background count");
    expRd(2'd0, 1'b1, 8'h22, "R2 load1 untouched");
    expRd(2'd2, 1'b1, 8'h09, "R2 opt1");

    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule